// File: doc/BRIEF.md
# Call Sequence Instruction Prefetcher

This block watches the call and return events of a processor front end and learns, for each function it tracks, the ordered list of functions that function calls. On a later pass through the same code it issues instruction prefetch requests for the callee expected next. The goal is to hide instruction cache misses on function entry. A small fully associative table holds one entry per function. Each entry has an identifier tag, an ordered list of five callee slots, and a position pointer into that list.

A call from X to Y records Y in X's list at X's current position. If Y is already tracked, the call requests a prefetch of the first callee in Y's list. If Y is not tracked, the call claims an entry for Y. A return from Y to X rewinds Y's pointer to the first slot and moves X's pointer one slot forward. It then requests a prefetch of the function stored in X's new slot. Requests are placed in a small queue that the fetch unit drains through a valid/ready handshake. A request that finds the queue full is discarded and counted.

Top module: `callseq_prefetcher`

## Requirements
- R1: After reset the request queue is empty (pfValid low), dropCount is 0 and no function is tracked, so no call or return produces a request until the table has learned again.
- R2: A call whose callee is not tracked claims an entry for it with an empty list and its pointer on slot 1. That call issues no request.
- R3: A call whose callee is tracked issues one request carrying the function in slot 1 of the callee's list when that slot is filled, and no request when it is empty.
- R4: A call writes the callee into the caller's list at the slot the caller's pointer names, overwriting any earlier value there. A call never moves any pointer.
- R5: A return rewinds the pointer of the returning function to slot 1.
- R6: A return moves the caller's pointer one slot forward and issues a request for the function in the new slot if that slot is filled. If the slot is empty, no request is issued but the pointer still moves.
- R7: A pointer that is on slot 5 stays there on a return, with no request. A later call from that function overwrites slot 5.
- R8: The table holds 16 functions. A new function takes the lowest-numbered free entry, or, when all entries are in use, the entry least recently named as a callee. Only calls count as a use, and they count for the callee only.
- R9: When a call and a return arrive in the same cycle, the call's effects are applied first and the return sees them. The call's request is queued ahead of the return's request.
- R10: Requests leave the 4-entry queue in issue order. pfFunc holds steady while pfValid is high and pfReady is low. One request leaves per cycle in which both are high.
- R11: A request that finds no room in the queue (judged on the occupancy at the start of the cycle) is discarded. dropCount rises by the number discarded in that cycle, up to 2, and saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| callValid | input | 1 | A call event is present this cycle |
| callCaller | input | 8 | Identifier of the calling function |
| callCallee | input | 8 | Identifier of the called function |
| retValid | input | 1 | A return event is present this cycle |
| retFunc | input | 8 | Identifier of the returning function |
| retCaller | input | 8 | Identifier of the function being returned to |
| pfValid | output | 1 | A prefetch request is offered |
| pfReady | input | 1 | The fetch unit takes the offered request |
| pfFunc | output | 8 | Identifier of the function to prefetch |
| dropCount | output | 8 | Number of requests discarded because the queue was full |

## Verification
The hardest situations to reach from the ports are a call and a return in the same cycle where the return depends on what the call has just changed. Examples are a return whose caller only exists because the call claimed it, and a return that advances the same list the call writes into. The stimulus reaches them by building lists with earlier single events, then firing both strobes together. The outcome is read back later, through the requests that replaying the list produces. Overflow is reached the same way: the queue is filled by holding pfReady low, then a double event forces two discards in one cycle.

// File: rtl/callseq_pkg.sv
package callseq_pkg;
  localparam int ENTRIES = 16;
  localparam int SLOTS   = 5;
  localparam int FID_W   = 8;
  localparam int QDEPTH  = 4;   // power of two
  localparam int DROP_W  = 8;

  localparam int ENT_W  = $clog2(ENTRIES);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int QPTR_W = $clog2(QDEPTH);

  typedef logic [FID_W-1:0]  fid_t;
  typedef logic [ENT_W-1:0]  ent_t;
  typedef logic [SLOT_W-1:0] slot_t;

  localparam slot_t LAST_SLOT = slot_t'(SLOTS - 1);
  localparam ent_t  OLDEST    = ent_t'(ENTRIES - 1);

  // Strobes from control to the table storage
  typedef struct packed {
    logic  allocEn;
    ent_t  allocEnt;
    fid_t  allocTag;
    logic  recEn;
    ent_t  recEnt;
    slot_t recSlot;
    fid_t  recId;
    logic  touchEn;
    ent_t  touchEnt;
    logic  rstIdxEn;
    ent_t  rstIdxEnt;
    logic  advEn;
    ent_t  advEnt;
    slot_t advIdx;
  } tbl_op_t;

  typedef struct packed {
    logic callPf;
    fid_t callPfId;
    logic retPf;
    fid_t retPfId;
  } pf_req_t;

  function automatic ent_t firstSet(input logic [ENTRIES-1:0] v);
    firstSet = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (v[i]) firstSet = ent_t'(i);
  endfunction
endpackage

// File: rtl/callseq_table.sv
module callseq_table import callseq_pkg::*; (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  tbl_op_t                                op,
  output logic [ENTRIES-1:0]                     entValid,
  output logic [ENTRIES-1:0][FID_W-1:0]          entTag,
  output logic [ENTRIES-1:0][SLOT_W-1:0]         entIdx,
  output logic [ENTRIES-1:0][SLOTS-1:0][FID_W-1:0] entSeq,
  output logic [ENTRIES-1:0][SLOTS-1:0]          entSeqVld,
  output logic [ENTRIES-1:0][ENT_W-1:0]          entAge
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entValid  <= '0;
      entTag    <= '0;
      entIdx    <= '0;
      entSeq    <= '0;
      entSeqVld <= '0;
      for (int i = 0; i < ENTRIES; i++) entAge[i] <= ent_t'(i);
    end else begin
      if (op.allocEn) begin
        entValid[op.allocEnt]  <= 1'b1;
        entTag[op.allocEnt]    <= op.allocTag;
        entSeqVld[op.allocEnt] <= '0;
        entIdx[op.allocEnt]    <= '0;
      end
      if (op.recEn) begin
        entSeq[op.recEnt][op.recSlot]    <= op.recId;
        entSeqVld[op.recEnt][op.recSlot] <= 1'b1;
      end
      if (op.rstIdxEn) entIdx[op.rstIdxEnt] <= '0;
      if (op.advEn)    entIdx[op.advEnt]    <= op.advIdx;
      if (op.touchEn) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (ent_t'(i) == op.touchEnt)
            entAge[i] <= '0;
          else if (entAge[i] < entAge[op.touchEnt])
            entAge[i] <= entAge[i] + ent_t'(1);
        end
      end
    end
  end

  // Checks on stored state
  logic [ENTRIES-1:0] ageTop, idxOk;
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      ageTop[i] = (entAge[i] == OLDEST);
      idxOk[i]  = (entIdx[i] <= LAST_SLOT);
    end
  end

  assert_single_oldest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ageTop) == 1);
  assert_index_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    &idxOk);
endmodule

// File: rtl/callseq_ctrl.sv
module callseq_ctrl import callseq_pkg::*; (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   callValid,
  input  fid_t                                   callCaller,
  input  fid_t                                   callCallee,
  input  logic                                   retValid,
  input  fid_t                                   retFunc,
  input  fid_t                                   retCaller,
  input  logic [ENTRIES-1:0]                     entValid,
  input  logic [ENTRIES-1:0][FID_W-1:0]          entTag,
  input  logic [ENTRIES-1:0][SLOT_W-1:0]         entIdx,
  input  logic [ENTRIES-1:0][SLOTS-1:0][FID_W-1:0] entSeq,
  input  logic [ENTRIES-1:0][SLOTS-1:0]          entSeqVld,
  input  logic [ENTRIES-1:0][ENT_W-1:0]          entAge,
  output tbl_op_t                                op,
  output pf_req_t                                pfReq
);
  logic [ENTRIES-1:0]            calleeMatch, callerMatch, selfMatch, parentMatch, postValid;
  logic [ENTRIES-1:0][FID_W-1:0] postTag;
  logic  calleeHit, callerHit, selfHit, parentHit, alloc, nextFilled;
  ent_t  calleeEnt, callerEnt, selfEnt, parentEnt, victim, dstEnt;
  slot_t base, nextSlot;
  fid_t  nextId;

  always_comb begin
    // replacement choice: oldest entry, overridden by the lowest free entry
    victim = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (entAge[i] == OLDEST) victim = ent_t'(i);
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!entValid[i]) victim = ent_t'(i);

    // call lookups on the state before this cycle
    for (int i = 0; i < ENTRIES; i++) begin
      calleeMatch[i] = entValid[i] && (entTag[i] == callCallee);
      callerMatch[i] = entValid[i] && (entTag[i] == callCaller);
    end
    calleeHit = |calleeMatch;
    callerHit = |callerMatch;
    calleeEnt = firstSet(calleeMatch);
    callerEnt = firstSet(callerMatch);
    alloc     = callValid && !calleeHit;
    dstEnt    = calleeHit ? calleeEnt : victim;

    // return lookups see the tags as the call leaves them
    postValid = entValid;
    postTag   = entTag;
    if (alloc) begin
      postValid[victim] = 1'b1;
      postTag[victim]   = callCallee;
    end
    for (int i = 0; i < ENTRIES; i++) begin
      selfMatch[i]   = postValid[i] && (postTag[i] == retFunc);
      parentMatch[i] = postValid[i] && (postTag[i] == retCaller);
    end
    selfHit   = |selfMatch;
    parentHit = |parentMatch;
    selfEnt   = firstSet(selfMatch);
    parentEnt = firstSet(parentMatch);

    op    = '0;
    pfReq = '0;

    if (callValid) begin
      op.touchEn  = 1'b1;
      op.touchEnt = dstEnt;
      op.allocEn  = alloc;
      op.allocEnt = victim;
      op.allocTag = callCallee;
      if (calleeHit && entSeqVld[calleeEnt][0]) begin
        pfReq.callPf   = 1'b1;
        pfReq.callPfId = entSeq[calleeEnt][0];
      end
      if (callerHit && !(alloc && callerEnt == victim)) begin
        op.recEn   = 1'b1;
        op.recEnt  = callerEnt;
        op.recSlot = entIdx[callerEnt];
        op.recId   = callCallee;
      end
    end

    // caller pointer after the call and after rewinding the returning function
    base = entIdx[parentEnt];
    if ((alloc && parentEnt == victim) || (selfHit && selfEnt == parentEnt))
      base = '0;
    nextSlot   = base + slot_t'(1);
    nextFilled = 1'b0;
    nextId     = '0;
    if (base != LAST_SLOT) begin
      nextFilled = entSeqVld[parentEnt][nextSlot];
      nextId     = entSeq[parentEnt][nextSlot];
    end
    if (alloc && parentEnt == victim) begin
      nextFilled = 1'b0;
    end else if (op.recEn && op.recEnt == parentEnt && op.recSlot == nextSlot) begin
      nextFilled = 1'b1;
      nextId     = callCallee;
    end

    if (retValid) begin
      if (selfHit) begin
        op.rstIdxEn  = 1'b1;
        op.rstIdxEnt = selfEnt;
      end
      if (parentHit && base != LAST_SLOT) begin
        op.advEn  = 1'b1;
        op.advEnt = parentEnt;
        op.advIdx = nextSlot;
        if (nextFilled) begin
          pfReq.retPf   = 1'b1;
          pfReq.retPfId = nextId;
        end
      end
    end
  end

  assert_unique_tags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(calleeMatch) <= 1 && $countones(callerMatch) <= 1);
  assert_alloc_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op.allocEn |-> (!entValid[op.allocEnt] || entAge[op.allocEnt] == OLDEST));
  assert_record_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op.recEn |-> (op.recSlot <= LAST_SLOT && entValid[op.recEnt]));
endmodule

// File: rtl/callseq_queue.sv
module callseq_queue import callseq_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  pf_req_t           pfReq,
  input  logic              pfReady,
  output logic              pfValid,
  output fid_t              pfFunc,
  output logic [DROP_W-1:0] dropCount
);
  logic [QDEPTH-1:0][FID_W-1:0] mem;
  logic [QPTR_W-1:0] wrPtr, rdPtr;
  logic [QPTR_W:0]   count, freeSlots;
  logic              acc0, acc1, pop;
  logic [1:0]        dropNow;
  logic [DROP_W:0]   dropSum;

  always_comb begin
    freeSlots = (QPTR_W+1)'(QDEPTH) - count;
    acc0      = pfReq.callPf && (freeSlots != '0);
    acc1      = pfReq.retPf && (acc0 ? (freeSlots >= (QPTR_W+1)'(2)) : (freeSlots != '0));
    dropNow   = {1'b0, pfReq.callPf && !acc0} + {1'b0, pfReq.retPf && !acc1};
    dropSum   = {1'b0, dropCount} + (DROP_W+1)'(dropNow);
    pfValid   = (count != '0);
    pfFunc    = mem[rdPtr];
    pop       = pfValid && pfReady;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem       <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      dropCount <= '0;
    end else begin
      if (acc0) mem[wrPtr] <= pfReq.callPfId;
      if (acc1) mem[wrPtr + QPTR_W'(acc0)] <= pfReq.retPfId;
      wrPtr <= wrPtr + QPTR_W'(acc0) + QPTR_W'(acc1);
      rdPtr <= rdPtr + QPTR_W'(pop);
      count <= count + (QPTR_W+1)'(acc0) + (QPTR_W+1)'(acc1) - (QPTR_W+1)'(pop);
      dropCount <= dropSum[DROP_W] ? '1 : dropSum[DROP_W-1:0];
    end
  end

  assert_queue_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (QPTR_W+1)'(QDEPTH));
  assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pfValid && !pfReady) |=> (pfValid && $stable(pfFunc)));
  assert_drop_monotonic_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dropCount >= $past(dropCount));
endmodule

// File: rtl/callseq_prefetcher.sv
module callseq_prefetcher import callseq_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              callValid,
  input  logic [FID_W-1:0]  callCaller,
  input  logic [FID_W-1:0]  callCallee,
  input  logic              retValid,
  input  logic [FID_W-1:0]  retFunc,
  input  logic [FID_W-1:0]  retCaller,
  output logic              pfValid,
  input  logic              pfReady,
  output logic [FID_W-1:0]  pfFunc,
  output logic [DROP_W-1:0] dropCount
);
  tbl_op_t                                 op;
  pf_req_t                                 pfReq;
  logic [ENTRIES-1:0]                      entValid;
  logic [ENTRIES-1:0][FID_W-1:0]           entTag;
  logic [ENTRIES-1:0][SLOT_W-1:0]          entIdx;
  logic [ENTRIES-1:0][SLOTS-1:0][FID_W-1:0] entSeq;
  logic [ENTRIES-1:0][SLOTS-1:0]           entSeqVld;
  logic [ENTRIES-1:0][ENT_W-1:0]           entAge;

  callseq_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .callValid(callValid), .callCaller(callCaller), .callCallee(callCallee),
    .retValid(retValid), .retFunc(retFunc), .retCaller(retCaller),
    .entValid(entValid), .entTag(entTag), .entIdx(entIdx),
    .entSeq(entSeq), .entSeqVld(entSeqVld), .entAge(entAge),
    .op(op), .pfReq(pfReq)
  );

  callseq_table i_table (
    .clk(clk), .rst_n(rst_n), .op(op),
    .entValid(entValid), .entTag(entTag), .entIdx(entIdx),
    .entSeq(entSeq), .entSeqVld(entSeqVld), .entAge(entAge)
  );

  callseq_queue i_queue (
    .clk(clk), .rst_n(rst_n), .pfReq(pfReq), .pfReady(pfReady),
    .pfValid(pfValid), .pfFunc(pfFunc), .dropCount(dropCount)
  );
endmodule

// File: tb/test_callseq_prefetcher.sv
module test_callseq_prefetcher;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       callValid = 1'b0, retValid = 1'b0, pfReady = 1'b0;
  logic [7:0] callCaller = '0, callCallee = '0, retFunc = '0, retCaller = '0;
  logic       pfValid;
  logic [7:0] pfFunc, dropCount;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;   // 50 MHz

  callseq_prefetcher i_callseq_prefetcher (
    .clk(clk), .rst_n(rst_n),
    .callValid(callValid), .callCaller(callCaller), .callCallee(callCallee),
    .retValid(retValid), .retFunc(retFunc), .retCaller(retCaller),
    .pfValid(pfValid), .pfReady(pfReady), .pfFunc(pfFunc), .dropCount(dropCount)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0; callValid = 1'b0; retValid = 1'b0; pfReady = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic evt(input bit c, input int cx, input int cy,
                     input bit r, input int ry, input int rx);
    callValid = c; callCaller = 8'(cx); callCallee = 8'(cy);
    retValid  = r; retFunc    = 8'(ry); retCaller  = 8'(rx);
    @(posedge clk);
    @(negedge clk);
    callValid = 1'b0; retValid = 1'b0;
  endtask

  task automatic doCall(input int x, input int y); evt(1, x, y, 0, 0, 0); endtask
  task automatic doRet(input int y, input int x);  evt(0, 0, 0, 1, y, x); endtask

  task automatic expectPf(input string req, input int id);
    chk(pfValid && pfFunc == 8'(id), req, pfValid ? int'(pfFunc) : -1, id);
    pfReady = 1'b1;
    @(negedge clk);
    pfReady = 1'b0;
  endtask

  task automatic expectNone(input string req);
    chk(!pfValid, req, pfValid ? int'(pfFunc) : -1, -1);
  endtask

  task automatic tResetState();
    chk(!pfValid, "R1 valid", int'(pfValid), 0);
    chk(dropCount == 0, "R1 drops", int'(dropCount), 0);
    doCall(1, 2); expectNone("R2 new callee");
    doCall(1, 2); expectNone("R3 empty list");
  endtask

  task automatic tLearnReplay();
    doCall(0, 10);  expectNone("R2");
    doCall(10, 20); expectNone("R2");
    doRet(20, 10);  expectNone("R6 empty slot");
    doCall(10, 21); expectNone("R2");
    doRet(21, 10);  expectNone("R6 empty slot");
    doCall(10, 22); expectNone("R2");
    doRet(22, 10);  expectNone("R6 empty slot");
    doRet(10, 0);   expectNone("R5");
    doCall(0, 10);  expectPf("R3 first callee", 20);
    doCall(10, 20); expectNone("R3 empty callee list");
    doRet(20, 10);  expectPf("R6 advance", 21);
    doCall(10, 21); expectNone("R3");
    doRet(21, 10);  expectPf("R6 advance", 22);
    doCall(10, 30); expectNone("R4 overwrite");
    doRet(10, 0);
    doCall(0, 10);  expectPf("R5 rewind", 20);
    doRet(20, 10);  expectPf("R5 rewind", 21);
    doRet(21, 10);  expectPf("R4 overwritten slot", 30);
  endtask

  task automatic tSaturate();
    doCall(0, 40); expectNone("R2");
    for (int k = 0; k < 5; k++) begin
      doCall(40, 50 + k); expectNone("R7 learn");
      doRet(50 + k, 40);  expectNone("R7 learn");
    end
    doCall(40, 59); expectNone("R7 last slot write");
    doRet(59, 40);  expectNone("R7 saturated");
    doRet(40, 0);
    doCall(0, 40);  expectPf("R3", 50);
    doRet(50, 40);  expectPf("R6", 51);
    doRet(51, 40);  expectPf("R6", 52);
    doRet(52, 40);  expectPf("R6", 53);
    doRet(53, 40);  expectPf("R7 last slot overwritten", 59);
    doRet(59, 40);  expectNone("R7 saturated");
  endtask

  task automatic tSameCycle();
    doCall(0, 40); expectNone("R1 table cleared");
    doCall(0, 60);
    doCall(60, 61);
    doRet(61, 60);
    doCall(60, 62);
    doRet(62, 60);
    doRet(60, 0);
    doCall(61, 63); expectNone("R9 setup");
    evt(1, 0, 61, 1, 61, 60);
    expectPf("R9 call request first", 63);
    expectPf("R9 return request second", 62);
    evt(1, 60, 65, 1, 65, 60); expectNone("R9 both no request");
    doRet(60, 0);
    doRet(61, 60); expectPf("R9 call recorded before advance", 65);
    evt(1, 0, 70, 1, 66, 70); expectNone("R9 new caller");
    doCall(70, 71);
    doRet(70, 0);
    doRet(71, 70); expectPf("R9 return saw allocated caller", 71);
  endtask

  task automatic tLru();
    doCall(0, 100);
    doCall(100, 101);
    doCall(101, 100); expectPf("R8 setup", 101);
    for (int k = 102; k <= 115; k++) doCall(0, k);
    doCall(0, 116);   expectNone("R8 full table alloc");
    doCall(0, 100);   expectPf("R8 recently used kept", 101);
    doCall(0, 101);   expectNone("R8 oldest evicted");
  endtask

  task automatic tQueue();
    doCall(0, 90);
    for (int k = 1; k <= 5; k++) begin
      doCall(90, 90 + k);
      doRet(90 + k, 90);
    end
    doRet(90, 0);
    doRet(91, 90);
    doRet(92, 90);
    doRet(93, 90);
    doRet(94, 90);
    chk(pfValid && pfFunc == 8'd92, "R10 head", int'(pfFunc), 92);
    chk(dropCount == 0, "R11 no drop yet", int'(dropCount), 0);
    doCall(0, 90);
    chk(dropCount == 1, "R11 single drop", int'(dropCount), 1);
    doRet(90, 0);
    evt(1, 0, 90, 1, 91, 90);
    chk(dropCount == 3, "R11 double drop", int'(dropCount), 3);
    chk(pfValid && pfFunc == 8'd92, "R10 stable while stalled", int'(pfFunc), 92);
    pfReady = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk(pfValid && pfFunc == 8'(92 + k), "R10 order", pfValid ? int'(pfFunc) : -1, 92 + k);
      @(negedge clk);
    end
    pfReady = 1'b0;
    chk(!pfValid, "R10 drained", int'(pfValid), 0);
  endtask

  initial begin
    doReset();
    tResetState();
    tLearnReplay();
    tSaturate();
    doReset();
    tSameCycle();
    doReset();
    tLru();
    doReset();
    tQueue();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule